// File: doc/BRIEF.md
# Trap condition evaluator

This block decides whether a conditional trap fires. It compares a register operand with a second value and derives five relations between them. The second value is either another register or a sign-extended immediate. A 5-bit select mask, taken from the instruction, picks which of those relations should cause a trap. If any picked relation holds, the block raises a program-interrupt request for exactly one cycle.

The select mask covers signed and unsigned ordering as well as equality. One evaluation can therefore test any mix of them, such as "signed below or unsigned above", without a separate compare for each. Instruction decode, interrupt vectoring and state saving belong to the surrounding pipeline. The registered relation flags are also brought out for debug.

Top module: `trap_eval`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `trap_o` is 0 and `rel_o` is 5'b00000.
- R2: One cycle after a `valid_i` strobe, `rel_o` shows the relations of that strobe's operands with this encoding: bit 4 signed A<B, bit 3 signed A>B, bit 2 A==B, bit 1 unsigned A<B, bit 0 unsigned A>B. For equal operands this gives 5'b00100.
- R3: Bits 4 and 3 treat both operands as two's-complement 32-bit values. For example, A=0xFFFFFFFF and B=1 sets bit 4 and clears bit 3.
- R4: Bits 1 and 0 treat both operands as unsigned 32-bit values. For example, A=0xFFFFFFFF and B=1 sets bit 0 and clears bit 1.
- R5: When `use_imm_i` is 1, B is `imm_i` sign extended from 16 to 32 bits and `src_b_i` is ignored. When `use_imm_i` is 0, B is `src_b_i`.
- R6: One cycle after a `valid_i` strobe, `trap_o` is 1 exactly when the bitwise AND of `sel_i` (same bit positions as `rel_o`) and that strobe's relations is non-zero.
- R7: A strobe with `sel_i` = 5'b00000 never raises `trap_o`, whatever the operands.
- R8: A strobe with `sel_i` = 5'b11000 (signed less or greater) or 5'b00011 (unsigned less or greater) traps exactly when the operands differ.
- R9: In a cycle after which `valid_i` was 0, `trap_o` is 0 and `rel_o` keeps its previous value.
- R10: Each strobe gives at most one cycle of `trap_o`. A lone strobe followed by an idle cycle yields a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Evaluate the presented operands this cycle |
| use_imm_i | input | 1 | 1 selects the immediate as operand B |
| src_a_i | input | 32 | Register operand A |
| src_b_i | input | 32 | Register operand B |
| imm_i | input | 16 | Immediate operand, sign extended |
| sel_i | input | 5 | Relation select mask |
| trap_o | output | 1 | One-cycle program-interrupt request |
| rel_o | output | 5 | Relation flags of the last strobe |

## Verification
The only state in the block is the registered request and the flag register. A wrong value in either shows at the ports in the cycle right after the strobe that produced it. A stale flag register that fails to capture would also show, but only at the next strobe whose relations differ. Sequences of mixed strobes and idle cycles are therefore compared against a reference model every clock. Directed cases target sign boundaries, equal operands and the zero mask, where signed and unsigned ordering disagree.

// File: rtl/trap_eval.sv
`timescale 1ns/1ps
module trap_eval #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int REL_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic              use_imm_i,
  input  logic [DATA_W-1:0] src_a_i,
  input  logic [DATA_W-1:0] src_b_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [REL_W-1:0]  sel_i,
  output logic              trap_o,
  output logic [REL_W-1:0]  rel_o
);
  localparam int EXT_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] opnd_b;
  logic              is_eq, is_ult, is_slt;
  logic [REL_W-1:0]  rel_now;

  assign opnd_b  = use_imm_i ? {{EXT_W{imm_i[IMM_W-1]}}, imm_i} : src_b_i;
  assign is_eq   = (src_a_i == opnd_b);
  assign is_ult  = (src_a_i < opnd_b);
  assign is_slt  = ($signed(src_a_i) < $signed(opnd_b));
  assign rel_now = {is_slt, ~is_slt & ~is_eq, is_eq, is_ult, ~is_ult & ~is_eq};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_o <= 1'b0;
      rel_o  <= '0;
    end else begin
      trap_o <= valid_i & (|(rel_now & sel_i));
      if (valid_i) rel_o <= rel_now;
    end
  end
endmodule

module trap_eval_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        valid_i,
  input logic        use_imm_i,
  input logic [31:0] src_a_i,
  input logic [31:0] src_b_i,
  input logic [15:0] imm_i,
  input logic [4:0]  sel_i,
  input logic        trap_o,
  input logic [4:0]  rel_o
);
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> (!trap_o && $stable(rel_o)));
  assert_zero_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && sel_i == 5'b0) |=> !trap_o);
  assert_trap_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> (trap_o == |(rel_o & $past(sel_i))));
  assert_signed_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> ($countones(rel_o[4:2]) == 1));
  assert_unsigned_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> ($countones({rel_o[2], rel_o[1:0]}) == 1));
  assert_equal_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !use_imm_i && src_a_i == src_b_i) |=> (rel_o == 5'b00100));
  assert_imm_ext_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && use_imm_i && imm_i == 16'hFFFF && src_a_i == 32'hFFFFFFFF) |=> rel_o[2]);
endmodule

bind trap_eval trap_eval_chk chk_i (
  .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .use_imm_i(use_imm_i),
  .src_a_i(src_a_i), .src_b_i(src_b_i), .imm_i(imm_i), .sel_i(sel_i),
  .trap_o(trap_o), .rel_o(rel_o)
);

// File: tb/trap_eval_tb.sv
`timescale 1ns/1ps
module trap_eval_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic        use_imm_i = 1'b0;
  logic [31:0] src_a_i = '0;
  logic [31:0] src_b_i = '0;
  logic [15:0] imm_i = '0;
  logic [4:0]  sel_i = '0;
  logic        trap_o;
  logic [4:0]  rel_o;

  int n_run = 0;
  int n_fail = 0;
  logic [4:0] exp_rel = '0;
  logic       exp_trap = 1'b0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  trap_eval dut_i (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .use_imm_i(use_imm_i),
    .src_a_i(src_a_i), .src_b_i(src_b_i), .imm_i(imm_i), .sel_i(sel_i),
    .trap_o(trap_o), .rel_o(rel_o)
  );

  function automatic logic [4:0] model_rel(logic [31:0] a, logic [31:0] b);
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    longint ua = longint'({32'b0, a});
    longint ub = longint'({32'b0, b});
    return {sa < sb, sa > sb, ua == ub, ua < ub, ua > ub};
  endfunction

  task automatic check(string tag);
    n_run++;
    if (trap_o !== exp_trap || rel_o !== exp_rel) begin
      n_fail++;
      $display("FAIL %s: trap=%0b rel=%05b expected trap=%0b rel=%05b",
               tag, trap_o, rel_o, exp_trap, exp_rel);
    end
  endtask

  task automatic step(bit v, bit ui, logic [31:0] a, logic [31:0] b,
                      logic [15:0] im, logic [4:0] s, string tag);
    logic [31:0] bb;
    int imv;
    valid_i = v; use_imm_i = ui; src_a_i = a; src_b_i = b; imm_i = im; sel_i = s;
    imv = $signed(im);
    bb = ui ? 32'(imv) : b;
    if (v) begin
      exp_rel  = model_rel(a, bb);
      exp_trap = (exp_rel & s) != 5'b0;
    end else begin
      exp_trap = 1'b0;
    end
    @(posedge clk);
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: timeout actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset");

    step(1, 0, 32'd7, 32'd7, 16'h0, 5'b00100, "R2 equal");
    step(1, 0, 32'hFFFFFFFF, 32'd1, 16'h0, 5'b10000, "R3 signed lt");
    step(1, 0, 32'hFFFFFFFF, 32'd1, 16'h0, 5'b01000, "R3 signed gt masked");
    step(1, 0, 32'h80000000, 32'h7FFFFFFF, 16'h0, 5'b10000, "R3 min vs max");
    step(1, 0, 32'hFFFFFFFF, 32'd1, 16'h0, 5'b00001, "R4 unsigned gt");
    step(1, 0, 32'd1, 32'hFFFFFFFF, 16'h0, 5'b00010, "R4 unsigned lt");
    step(1, 1, 32'hFFFFFFFF, 32'd5, 16'hFFFF, 5'b00100, "R5 imm -1");
    step(1, 1, 32'h00008000, 32'h00008000, 16'h8000, 5'b00100, "R5 ext ignores srcb");
    step(1, 1, 32'hFFFF8000, 32'd0, 16'h8000, 5'b00100, "R5 imm min");
    step(1, 1, 32'd3, 32'd3, 16'h0003, 5'b00100, "R5 imm pos");
    step(1, 0, 32'd9, 32'd9, 16'h0, 5'b11011, "R6 equal not selected");
    step(1, 0, 32'd9, 32'd9, 16'h0, 5'b00000, "R7 zero mask equal");
    step(1, 0, 32'h1, 32'hFFFFFFFF, 16'h0, 5'b00000, "R7 zero mask diff");
    step(1, 0, 32'd4, 32'd9, 16'h0, 5'b11000, "R8 signed ne differ");
    step(1, 0, 32'd9, 32'd9, 16'h0, 5'b11000, "R8 signed ne equal");
    step(1, 0, 32'h80000000, 32'd0, 16'h0, 5'b00011, "R8 unsigned ne differ");
    step(1, 0, 32'd0, 32'd0, 16'h0, 5'b00011, "R8 unsigned ne equal");
    step(1, 0, 32'd1, 32'd2, 16'h0, 5'b11111, "R10 pulse");
    step(0, 0, 32'd5, 32'd2, 16'h0, 5'b11111, "R10 pulse ends");
    step(0, 1, 32'd2, 32'd5, 16'h1, 5'b11111, "R9 idle holds");

    for (int i = 0; i < 400; i++) begin
      logic [31:0] a, b;
      bit ui, v;
      a = $urandom;
      b = ($urandom_range(0, 3) == 0) ? a : $urandom;
      ui = ($urandom_range(0, 3) == 0);
      if (ui && $urandom_range(0, 1) == 1) a = 32'($signed(b[15:0]));
      v = ($urandom_range(0, 4) != 0);
      step(v, ui, a, b, b[15:0], 5'($urandom), v ? "R6 random" : "R9 random idle");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule